// File: doc/BRIEF.md
# ModRM/SIB Effective Address Generator

This block turns the addressing bytes of a decoded instruction into an operand location. It receives the ModRM byte, the SIB byte (when one follows), up to four displacement bytes, the current address size and execution mode, the three REX extension bits, the address of the next instruction and an optional segment override from prefix decode. From these it either names a register operand or forms a linear memory address. For the address it picks the base and index registers, scales the index, adds the displacement, applies the default or overriding segment, adds that segment's base and truncates the result to the address width. It also reports how many displacement bytes the instruction consumed and whether a SIB byte was used, so that the fetch logic can step past them.

Register values and segment bases are read through two small combinational ports: the block drives the selectors in the request cycle and the surrounding logic returns the data in the same cycle. One request may be issued per clock and its result appears on the registered outputs one clock later.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and after it is released with no request, `res_valid` is 0 and `res_addr` is 0.
- R2: A request with `req_valid` high in cycle N produces `res_valid` high in cycle N+1. A cycle with `req_valid` low produces `res_valid` low in the next cycle.
- R3: With mod (bits 7:6 of `modrm`) equal to 3, `res_is_reg` is 1 and `res_reg` is {REX.B, rm (bits 2:0)}. `res_addr` is 0, `res_disp_len` is 0 and `res_sib_used` is 0.
- R4: `res_reg_field` is {REX.R, modrm bits 5:3} in every form. The REX bits `rex_r`, `rex_x` and `rex_b` act only when `mode64` is 1 and are otherwise treated as 0.
- R5: With `addr_size` 0 (16-bit), rm selects the register sum as follows: 0 gives BX+SI, 1 gives BX+DI, 2 gives BP+SI, 3 gives BP+DI, 4 gives SI, 5 gives DI, 6 gives BP and 7 gives BX. The register numbers are BX=3, BP=5, SI=6 and DI=7. Mod 1 adds the sign-extended byte `disp_in[7:0]` (length 1). Mod 2 adds `disp_in[15:0]` (length 2). Mod 0 with rm 6 is `disp_in[15:0]` alone (length 2). The sum wraps to 16 bits before the segment base is added.
- R6: The segment codes are ES=0, CS=1, SS=2, DS=3, FS=4 and GS=5. In 16-bit addressing, rm 2, rm 3, and rm 6 with a nonzero mod default to SS; every other form defaults to DS. In 32/64-bit addressing the default is DS. When `seg_ovr_valid` is high, `seg_ovr` replaces the default. `res_seg` reports the segment in use.
- R7: With `addr_size` 1 (32) or 2 (64) and rm 4 (unextended) with mod other than 3, a SIB byte is used. Its bits 7:6 give the shift count applied to the index. Its bits 5:3 give the index, extended by REX.X. Its bits 2:0 give the base, extended by REX.B. An index of exactly 4 (REX.X clear) adds no index.
- R8: A SIB base field of 5 with mod 0 adds no base register and instead adds the sign-extended `disp_in` (length 4). With mod 1 or 2, base field 5 names register 5 (or 13).
- R9: In 32/64-bit addressing, mod 1 adds the sign-extended `disp_in[7:0]` (length 1) and mod 2 adds the sign-extended `disp_in` (length 4). Otherwise the length is 0, except in the cases of R8 and R10.
- R10: With rm 5 (unextended) and mod 0 in 32/64-bit addressing, the address is the sign-extended `disp_in` with no base register and length 4. When `mode64` is 1, `next_ip` is added to it.
- R11: With `mode64` 1, the segment base is added only when the segment in use is FS or GS. With `mode64` 0 it is always added.
- R12: With `addr_size` 1, bits 63:32 of `res_addr` are 0, cleared after the segment base is added. With `addr_size` 2, all 64 bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| mode64 | input | 1 | 64-bit execution mode |
| addr_size | input | 2 | 0: 16-bit, 1: 32-bit, 2: 64-bit addressing |
| modrm | input | 8 | ModRM byte |
| sib | input | 8 | SIB byte (ignored when not used) |
| disp_in | input | 32 | Displacement bytes after ModRM/SIB, first byte in bits 7:0 |
| rex_r | input | 1 | REX register-field extension |
| rex_x | input | 1 | REX index extension |
| rex_b | input | 1 | REX base/rm extension |
| next_ip | input | 64 | Address of the next instruction |
| seg_ovr_valid | input | 1 | A segment override prefix is present |
| seg_ovr | input | 3 | Overriding segment code |
| rf_base_sel | output | 4 | Register file read selector for the base |
| rf_base_data | input | 64 | Base register value |
| rf_index_sel | output | 4 | Register file read selector for the index |
| rf_index_data | input | 64 | Index register value |
| seg_sel | output | 3 | Segment whose base is requested |
| seg_base | input | 64 | Base of the requested segment |
| res_valid | output | 1 | Result valid |
| res_is_reg | output | 1 | The operand is a register |
| res_reg | output | 4 | Register operand number |
| res_reg_field | output | 4 | Extended ModRM reg field |
| res_addr | output | 64 | Linear effective address |
| res_seg | output | 3 | Segment applied |
| res_disp_len | output | 3 | Displacement bytes consumed (0, 1, 2 or 4) |
| res_sib_used | output | 1 | A SIB byte was consumed |

## Verification
Every one of the 256 ModRM values is driven in 16-bit, 32-bit and 64-bit addressing, with varying SIB bytes, displacements and overrides, all under register values that differ in every byte lane. This separates each rm/mod form by its register pair, its displacement sign handling and its displacement length. Directed cases then target the forms that are easy to confuse: a negative byte displacement against a 16-bit wrap, SIB index 4 with and without REX.X, SIB base 5 under mod 0 against mod 1, and rm 5 under mod 0 inside and outside 64-bit mode. Further cases isolate the segment rules. FS and GS overrides are set against ES and DS in 64-bit mode, and 32-bit truncation is tested with segment bases that carry high bits. The REX bits are also set outside 64-bit mode to show that they have no effect there.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int RIDX_W = 4;

  typedef enum logic [2:0] {
    SEG_ES = 3'd0, SEG_CS = 3'd1, SEG_SS = 3'd2,
    SEG_DS = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
  } seg_e;

  typedef enum logic [1:0] {
    ASZ_16 = 2'd0, ASZ_32 = 2'd1, ASZ_64 = 2'd2
  } asz_e;

  typedef enum logic [1:0] {
    DSP_NONE = 2'd0, DSP_8 = 2'd1, DSP_16 = 2'd2, DSP_32 = 2'd3
  } dsp_e;

  // Address recipe produced by a form decoder
  typedef struct packed {
    logic              use_base;
    logic [RIDX_W-1:0] base_idx;
    logic              use_index;
    logic [RIDX_W-1:0] index_idx;
    logic [1:0]        scale;
    logic              rip_rel;
    dsp_e              dsp;
    logic              sib_used;
    seg_e              def_seg;
  } ea_plan_t;

  // Bytes of displacement implied by a displacement kind
  function automatic logic [2:0] dsp_bytes(input dsp_e k);
    case (k)
      DSP_8:   return 3'd1;
      DSP_16:  return 3'd2;
      DSP_32:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/eag_plan16.sv
module eag_plan16
  import eag_pkg::*;
(
  input  logic [1:0] md,
  input  logic [2:0] rm,
  output ea_plan_t   plan
);
  localparam logic [RIDX_W-1:0] IDX_BX = 4'd3;
  localparam logic [RIDX_W-1:0] IDX_BP = 4'd5;
  localparam logic [RIDX_W-1:0] IDX_SI = 4'd6;
  localparam logic [RIDX_W-1:0] IDX_DI = 4'd7;

  logic bare_disp;
  logic stack_form;
  assign bare_disp  = (md == 2'd0) && (rm == 3'd6);
  assign stack_form = (rm == 3'd2) || (rm == 3'd3) || ((rm == 3'd6) && !bare_disp);

  always_comb begin
    plan          = '0;
    plan.def_seg  = stack_form ? SEG_SS : SEG_DS;
    plan.dsp      = DSP_NONE;
    case (rm)
      3'd0: begin plan.use_base = 1'b1; plan.base_idx = IDX_BX;
                  plan.use_index = 1'b1; plan.index_idx = IDX_SI; end
      3'd1: begin plan.use_base = 1'b1; plan.base_idx = IDX_BX;
                  plan.use_index = 1'b1; plan.index_idx = IDX_DI; end
      3'd2: begin plan.use_base = 1'b1; plan.base_idx = IDX_BP;
                  plan.use_index = 1'b1; plan.index_idx = IDX_SI; end
      3'd3: begin plan.use_base = 1'b1; plan.base_idx = IDX_BP;
                  plan.use_index = 1'b1; plan.index_idx = IDX_DI; end
      3'd4: begin plan.use_index = 1'b1; plan.index_idx = IDX_SI; end
      3'd5: begin plan.use_index = 1'b1; plan.index_idx = IDX_DI; end
      3'd6: begin plan.use_base = !bare_disp; plan.base_idx = IDX_BP; end
      default: begin plan.use_base = 1'b1; plan.base_idx = IDX_BX; end
    endcase
    if (md == 2'd1)      plan.dsp = DSP_8;
    else if (md == 2'd2) plan.dsp = DSP_16;
    else if (bare_disp)  plan.dsp = DSP_16;
  end
endmodule

// File: rtl/eag_plan32.sv
module eag_plan32
  import eag_pkg::*;
(
  input  logic [1:0] md,
  input  logic [2:0] rm,
  input  logic [7:0] sib,
  input  logic       rex_x,
  input  logic       rex_b,
  input  logic       mode64,
  output ea_plan_t   plan
);
  localparam logic [RIDX_W-1:0] NO_INDEX = 4'd4;

  logic              has_sib;
  logic              sib_no_base;
  logic              abs_disp;
  logic [RIDX_W-1:0] sib_index;

  assign has_sib     = (rm == 3'd4) && (md != 2'd3);
  assign sib_no_base = has_sib && (sib[2:0] == 3'd5) && (md == 2'd0);
  assign abs_disp    = !has_sib && (rm == 3'd5) && (md == 2'd0);
  assign sib_index   = {rex_x, sib[5:3]};

  always_comb begin
    plan          = '0;
    plan.def_seg  = SEG_DS;
    plan.sib_used = has_sib;
    if (has_sib) begin
      plan.scale     = sib[7:6];
      plan.index_idx = sib_index;
      plan.use_index = (sib_index != NO_INDEX);
      plan.base_idx  = {rex_b, sib[2:0]};
      plan.use_base  = !sib_no_base;
    end else begin
      plan.base_idx  = {rex_b, rm};
      plan.use_base  = !abs_disp;
      plan.rip_rel   = abs_disp && mode64;
    end
    if (md == 2'd1)                     plan.dsp = DSP_8;
    else if (md == 2'd2)                plan.dsp = DSP_32;
    else if (sib_no_base || abs_disp)   plan.dsp = DSP_32;
    else                                plan.dsp = DSP_NONE;
  end
endmodule

// File: rtl/eag_combine.sv
module eag_combine
  import eag_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            use_base,
  input  logic            use_index,
  input  logic [1:0]      scale,
  input  logic            rip_rel,
  input  dsp_e            dsp,
  input  logic [1:0]      addr_size,
  input  logic            mode64,
  input  logic [2:0]      seg,
  input  logic [XLEN-1:0] base_data,
  input  logic [XLEN-1:0] index_data,
  input  logic [31:0]     disp_in,
  input  logic [XLEN-1:0] next_ip,
  input  logic [XLEN-1:0] seg_base,
  output logic [XLEN-1:0] ea_offset,
  output logic            seg_gate_open,
  output logic [XLEN-1:0] lin_addr
);
  localparam logic [XLEN-1:0] MASK16 = {{(XLEN-16){1'b0}}, 16'hFFFF};
  localparam logic [XLEN-1:0] MASK32 = {{(XLEN-32){1'b0}}, 32'hFFFF_FFFF};

  function automatic logic [XLEN-1:0] disp_ext(input dsp_e k, input logic [31:0] d);
    case (k)
      DSP_8:   return {{(XLEN-8){d[7]}}, d[7:0]};
      DSP_16:  return {{(XLEN-16){1'b0}}, d[15:0]};
      DSP_32:  return {{(XLEN-32){d[31]}}, d};
      default: return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] scaled(input logic [XLEN-1:0] v, input logic [1:0] s);
    return v << s;
  endfunction

  logic [XLEN-1:0] base_term;
  logic [XLEN-1:0] index_term;
  logic [XLEN-1:0] raw_sum;
  logic [XLEN-1:0] with_seg;

  assign base_term  = use_base ? base_data : (rip_rel ? next_ip : '0);
  assign index_term = use_index ? scaled(index_data, scale) : '0;
  assign raw_sum    = base_term + index_term + disp_ext(dsp, disp_in);
  assign ea_offset  = (addr_size == ASZ_16) ? (raw_sum & MASK16) : raw_sum;

  assign seg_gate_open = !mode64 || (seg == SEG_FS) || (seg == SEG_GS);
  assign with_seg      = ea_offset + (seg_gate_open ? seg_base : '0);
  assign lin_addr      = (addr_size == ASZ_32) ? (with_seg & MASK32) : with_seg;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import eag_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                mode64,
  input  logic [1:0]          addr_size,
  input  logic [7:0]          modrm,
  input  logic [7:0]          sib,
  input  logic [31:0]         disp_in,
  input  logic                rex_r,
  input  logic                rex_x,
  input  logic                rex_b,
  input  logic [XLEN-1:0]     next_ip,
  input  logic                seg_ovr_valid,
  input  logic [2:0]          seg_ovr,
  output logic [RIDX_W-1:0]   rf_base_sel,
  input  logic [XLEN-1:0]     rf_base_data,
  output logic [RIDX_W-1:0]   rf_index_sel,
  input  logic [XLEN-1:0]     rf_index_data,
  output logic [2:0]          seg_sel,
  input  logic [XLEN-1:0]     seg_base,
  output logic                res_valid,
  output logic                res_is_reg,
  output logic [RIDX_W-1:0]   res_reg,
  output logic [RIDX_W-1:0]   res_reg_field,
  output logic [XLEN-1:0]     res_addr,
  output logic [2:0]          res_seg,
  output logic [2:0]          res_disp_len,
  output logic                res_sib_used
);
  // REX bits only exist in 64-bit mode
  logic rex_r_e, rex_x_e, rex_b_e;
  assign rex_r_e = rex_r & mode64;
  assign rex_x_e = rex_x & mode64;
  assign rex_b_e = rex_b & mode64;

  logic [1:0] md;
  logic [2:0] rm;
  logic       reg_form;
  logic       form16;
  assign md       = modrm[7:6];
  assign rm       = modrm[2:0];
  assign reg_form = (md == 2'd3);
  assign form16   = (addr_size == ASZ_16);

  ea_plan_t plan16, plan32, plan;

  eag_plan16 u_plan16 (
    .md   (md),
    .rm   (rm),
    .plan (plan16)
  );

  eag_plan32 u_plan32 (
    .md     (md),
    .rm     (rm),
    .sib    (sib),
    .rex_x  (rex_x_e),
    .rex_b  (rex_b_e),
    .mode64 (mode64),
    .plan   (plan32)
  );

  assign plan = form16 ? plan16 : plan32;

  // Segment in use and register-file/segment read ports
  logic [2:0] seg_eff;
  assign seg_eff      = seg_ovr_valid ? seg_ovr : plan.def_seg;
  assign seg_sel      = seg_eff;
  assign rf_base_sel  = plan.base_idx;
  assign rf_index_sel = plan.index_idx;

  logic [XLEN-1:0] ea_offset;
  logic            seg_gate_open;
  logic [XLEN-1:0] lin_addr;

  eag_combine #(.XLEN(XLEN)) u_combine (
    .use_base      (plan.use_base),
    .use_index     (plan.use_index),
    .scale         (plan.scale),
    .rip_rel       (plan.rip_rel),
    .dsp           (plan.dsp),
    .addr_size     (addr_size),
    .mode64        (mode64),
    .seg           (seg_eff),
    .base_data     (rf_base_data),
    .index_data    (rf_index_data),
    .disp_in       (disp_in),
    .next_ip       (next_ip),
    .seg_base      (seg_base),
    .ea_offset     (ea_offset),
    .seg_gate_open (seg_gate_open),
    .lin_addr      (lin_addr)
  );

  // Result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_is_reg    <= 1'b0;
      res_reg       <= '0;
      res_reg_field <= '0;
      res_addr      <= '0;
      res_seg       <= '0;
      res_disp_len  <= '0;
      res_sib_used  <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_is_reg    <= reg_form;
        res_reg       <= reg_form ? {rex_b_e, rm} : '0;
        res_reg_field <= {rex_r_e, modrm[5:3]};
        res_addr      <= reg_form ? '0 : lin_addr;
        res_seg       <= seg_eff;
        res_disp_len  <= reg_form ? 3'd0 : dsp_bytes(plan.dsp);
        res_sib_used  <= !reg_form && plan.sib_used;
      end
    end
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R2
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  // R3
  reg_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_is_reg) |-> (res_addr == '0 && res_disp_len == 3'd0 && !res_sib_used));
  // R6
  ss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr_size == ASZ_16 && !seg_ovr_valid && modrm[7:6] != 2'd3 &&
     (modrm[2:0] == 3'd2 || modrm[2:0] == 3'd3)) |=> (res_seg == SEG_SS));
  // R5
  len16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr_size == ASZ_16) |=> (res_disp_len != 3'd4 && !res_sib_used));
  // R9
  disp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_disp_len) <= 1));
  // R12
  trunc32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr_size == ASZ_32 && modrm[7:6] != 2'd3) |=> (res_addr[XLEN-1:32] == '0));
  // R11
  seg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode64 && seg_eff != SEG_FS && seg_eff != SEG_GS) |-> (lin_addr == ea_offset ||
      addr_size == ASZ_32));
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic            req_valid = 1'b0;
  logic            mode64 = 1'b0;
  logic [1:0]      addr_size = 2'd0;
  logic [7:0]      modrm = 8'd0;
  logic [7:0]      sib = 8'd0;
  logic [31:0]     disp_in = 32'd0;
  logic            rex_r = 1'b0, rex_x = 1'b0, rex_b = 1'b0;
  logic [XLEN-1:0] next_ip = '0;
  logic            seg_ovr_valid = 1'b0;
  logic [2:0]      seg_ovr = 3'd0;
  logic [3:0]      rf_base_sel, rf_index_sel;
  logic [XLEN-1:0] rf_base_data, rf_index_data;
  logic [2:0]      seg_sel;
  logic [XLEN-1:0] seg_base;
  logic            res_valid, res_is_reg, res_sib_used;
  logic [3:0]      res_reg, res_reg_field;
  logic [XLEN-1:0] res_addr;
  logic [2:0]      res_seg, res_disp_len;

  logic [XLEN-1:0] regs [16];
  logic [XLEN-1:0] segs [8];

  assign rf_base_data  = regs[rf_base_sel];
  assign rf_index_data = regs[rf_index_sel];
  assign seg_base      = segs[seg_sel];

  ea_gen #(.XLEN(XLEN)) u_ea_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode64(mode64),
    .addr_size(addr_size), .modrm(modrm), .sib(sib), .disp_in(disp_in),
    .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b), .next_ip(next_ip),
    .seg_ovr_valid(seg_ovr_valid), .seg_ovr(seg_ovr),
    .rf_base_sel(rf_base_sel), .rf_base_data(rf_base_data),
    .rf_index_sel(rf_index_sel), .rf_index_data(rf_index_data),
    .seg_sel(seg_sel), .seg_base(seg_base),
    .res_valid(res_valid), .res_is_reg(res_is_reg), .res_reg(res_reg),
    .res_reg_field(res_reg_field), .res_addr(res_addr), .res_seg(res_seg),
    .res_disp_len(res_disp_len), .res_sib_used(res_sib_used)
  );

  typedef struct packed {
    logic            is_reg;
    logic [3:0]      rg;
    logic [3:0]      rfield;
    logic [XLEN-1:0] addr;
    logic [2:0]      seg;
    logic [2:0]      len;
    logic            sibu;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // Independent model of the requirements
  function automatic exp_t model(input logic m64, input logic [1:0] asz, input logic [7:0] mrm,
                                 input logic [7:0] sb, input logic [31:0] d, input logic rr,
                                 input logic rx, input logic rb, input logic ovv,
                                 input logic [2:0] ov, input logic [XLEN-1:0] nip);
    exp_t e;
    logic [1:0] mo; logic [2:0] r;
    logic er, ex, eb, long_d;
    logic [XLEN-1:0] bv, iv, dv, ea;
    logic [15:0] s16;
    logic [2:0] dseg, sg;
    logic [3:0] ix;
    e = '0;
    mo = mrm[7:6]; r = mrm[2:0];
    er = rr & m64; ex = rx & m64; eb = rb & m64;
    e.rfield = {er, mrm[5:3]};
    if (mo == 2'd3) begin
      e.is_reg = 1'b1;
      e.rg = {eb, r};
      return e;
    end
    dseg = 3'd3;
    if (asz == 2'd0) begin
      case (r)
        3'd0: s16 = regs[3][15:0] + regs[6][15:0];
        3'd1: s16 = regs[3][15:0] + regs[7][15:0];
        3'd2: s16 = regs[5][15:0] + regs[6][15:0];
        3'd3: s16 = regs[5][15:0] + regs[7][15:0];
        3'd4: s16 = regs[6][15:0];
        3'd5: s16 = regs[7][15:0];
        3'd6: s16 = (mo == 2'd0) ? 16'd0 : regs[5][15:0];
        default: s16 = regs[3][15:0];
      endcase
      if (mo == 2'd1) begin s16 = s16 + {{8{d[7]}}, d[7:0]}; e.len = 3'd1; end
      else if (mo == 2'd2 || r == 3'd6) begin s16 = s16 + d[15:0]; e.len = 3'd2; end
      if (r == 3'd2 || r == 3'd3 || (r == 3'd6 && mo != 2'd0)) dseg = 3'd2;
      ea = {48'd0, s16};
    end else begin
      long_d = 1'b0; iv = '0; bv = '0;
      if (r == 3'd4) begin
        e.sibu = 1'b1;
        ix = {ex, sb[5:3]};
        if (ix != 4'd4) iv = regs[ix] << sb[7:6];
        if (sb[2:0] == 3'd5 && mo == 2'd0) long_d = 1'b1;
        else bv = regs[{eb, sb[2:0]}];
      end else if (r == 3'd5 && mo == 2'd0) begin
        long_d = 1'b1;
        bv = m64 ? nip : '0;
      end else begin
        bv = regs[{eb, r}];
      end
      dv = '0;
      if (mo == 2'd1) begin dv = {{56{d[7]}}, d[7:0]}; e.len = 3'd1; end
      else if (mo == 2'd2 || long_d) begin dv = {{32{d[31]}}, d}; e.len = 3'd4; end
      ea = bv + iv + dv;
    end
    sg = ovv ? ov : dseg;
    e.seg = sg;
    if (!m64 || sg == 3'd4 || sg == 3'd5) ea = ea + segs[sg];
    if (asz == 2'd1) ea[63:32] = 32'd0;
    e.addr = ea;
    return e;
  endfunction

  task automatic send(input logic m64, input logic [1:0] asz, input logic [7:0] mrm,
                      input logic [7:0] sb, input logic [31:0] d, input logic rr,
                      input logic rx, input logic rb, input logic ovv, input logic [2:0] ov,
                      input logic [XLEN-1:0] nip, input string tag);
    @(negedge clk);
    mode64 = m64; addr_size = asz; modrm = mrm; sib = sb; disp_in = d;
    rex_r = rr; rex_x = rx; rex_b = rb; seg_ovr_valid = ovv; seg_ovr = ov;
    next_ip = nip; req_valid = 1'b1;
    exp_q.push_back(model(m64, asz, mrm, sb, d, rr, rx, rb, ovv, ov, nip));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops expected items as results appear
  always @(posedge clk) begin
    #2;
    if (rst_n && res_valid && !done) begin
      exp_t e; string t; bit bad;
      bad = 1'b0;
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: unexpected result, actual res_valid=1 expected 0");
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        n_cmp++;
        if (res_is_reg !== e.is_reg) begin bad = 1'b1;
          $display("FAIL %s/R3: is_reg actual %0b expected %0b", t, res_is_reg, e.is_reg); end
        if (res_reg_field !== e.rfield) begin bad = 1'b1;
          $display("FAIL %s/R4: reg_field actual %0h expected %0h", t, res_reg_field, e.rfield); end
        if (res_disp_len !== e.len) begin bad = 1'b1;
          $display("FAIL %s: disp_len actual %0d expected %0d", t, res_disp_len, e.len); end
        if (res_sib_used !== e.sibu) begin bad = 1'b1;
          $display("FAIL %s/R7: sib_used actual %0b expected %0b", t, res_sib_used, e.sibu); end
        if (e.is_reg) begin
          if (res_reg !== e.rg) begin bad = 1'b1;
            $display("FAIL %s/R3: reg actual %0h expected %0h", t, res_reg, e.rg); end
          if (res_addr !== '0) begin bad = 1'b1;
            $display("FAIL %s/R3: addr actual %0h expected 0", t, res_addr); end
        end else begin
          if (res_addr !== e.addr) begin bad = 1'b1;
            $display("FAIL %s: addr actual %0h expected %0h", t, res_addr, e.addr); end
          if (res_seg !== e.seg) begin bad = 1'b1;
            $display("FAIL %s/R6: seg actual %0d expected %0d", t, res_seg, e.seg); end
        end
        if (bad) n_bad++;
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++)
      regs[i] = 64'h8000_0000_0000_7000 + 64'(i) * 64'h0101_0202_0303_1111;
    for (int k = 0; k < 8; k++)
      segs[k] = 64'(k + 1) * 64'h0000_0100_0001_0000;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    n_cmp++;
    if (res_valid !== 1'b0 || res_addr !== '0) begin
      n_bad++;
      $display("FAIL R1: during reset valid=%0b addr=%0h expected 0/0", res_valid, res_addr);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    n_cmp++;
    if (res_valid !== 1'b0 || res_addr !== '0) begin
      n_bad++;
      $display("FAIL R1: after reset valid=%0b addr=%0h expected 0/0", res_valid, res_addr);
    end

    // R5 R6: 16-bit forms, directed
    for (int r = 0; r < 8; r++)
      send(1'b0, 2'd0, 8'(8'h40 | r), 8'h00, 32'h0000_0080, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R5");
    send(1'b0, 2'd0, 8'h06, 8'h00, 32'h0000_FFF0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R5");
    send(1'b0, 2'd0, 8'h86, 8'h00, 32'h0000_9000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R6");
    send(1'b0, 2'd0, 8'h02, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, '0, "R6");
    send(1'b0, 2'd0, 8'hC5, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R3");
    // R4: REX ignored outside 64-bit mode
    send(1'b0, 2'd1, 8'hC9, 8'h00, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, '0, "R4");
    send(1'b0, 2'd1, 8'h04, 8'h25, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, '0, "R4");
    idle();
    // R2: gap produces no result
    @(posedge clk); #2;
    n_cmp++;
    if (res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: idle cycle actual res_valid=%0b expected 0", res_valid);
    end

    // 32-bit forms
    send(1'b0, 2'd1, 8'h00, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R12");
    send(1'b0, 2'd1, 8'h43, 8'h00, 32'h0000_00F0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R9");
    send(1'b0, 2'd1, 8'h81, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R9");
    send(1'b0, 2'd1, 8'h05, 8'h00, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 64'hFFFF, "R10");
    send(1'b0, 2'd1, 8'h44, 8'hCA, 32'h0000_0011, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R7");
    send(1'b0, 2'd1, 8'h04, 8'h20, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R7");
    send(1'b0, 2'd1, 8'h04, 8'h0D, 32'hFFFF_FF00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R8");
    send(1'b0, 2'd1, 8'h44, 8'h0D, 32'h0000_007F, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R8");

    // 64-bit mode
    send(1'b1, 2'd2, 8'h05, 8'h00, 32'hFFFF_FFF0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0,
         64'h0000_7FFF_0000_1000, "R10");
    send(1'b1, 2'd2, 8'h00, 8'h00, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, '0, "R11");
    send(1'b1, 2'd2, 8'h00, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, '0, "R11");
    send(1'b1, 2'd2, 8'h00, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, '0, "R11");
    send(1'b1, 2'd2, 8'h00, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, '0, "R11");
    send(1'b1, 2'd2, 8'h04, 8'h60, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, '0, "R7");
    send(1'b1, 2'd2, 8'h38, 8'h00, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R4");
    send(1'b1, 2'd1, 8'h05, 8'h00, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4,
         64'h1234_5678_FFFF_FFF8, "R12");
    send(1'b1, 2'd2, 8'hC2, 8'h00, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, '0, "R3");

    // Sweeps over every ModRM value in each addressing form
    for (int i = 0; i < 256; i++)
      send(1'b0, 2'd0, 8'(i), 8'(i * 37 + 11), 32'(i) * 32'h9E37_79B1, 1'b0, 1'b0, 1'b0,
           i[1], 3'(i % 6), '0, "R5");
    for (int i = 0; i < 256; i++)
      send(1'b0, 2'd1, 8'(i), 8'(i * 53 + 7), 32'(i) * 32'h85EB_CA6B, 1'b0, 1'b0, 1'b0,
           i[2], 3'(i % 6), 64'h0000_0000_0040_0000, "R7");
    for (int i = 0; i < 256; i++)
      send(1'b1, 2'd2, 8'(i), 8'(i * 29 + 3), 32'(i) * 32'hC2B2_AE35, i[3], i[4], i[5],
           i[0], 3'(i % 6), 64'h0000_7FFF_1000_0000, "R11");
    idle();
    repeat (4) @(posedge clk);
    #3;
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R2: watchdog expired, actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule